// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square integer matrices, C = A×B, on an N×N grid of multiply-accumulate cells. A tile is fed as N beats. On beat k the caller presents column k of A and row k of B. Edge feeders skew each lane so that row r of A enters the grid r cycles late and column c of B enters c cycles late. A values step one cell to the right per cycle, and B values step one cell down per cycle. Cell (i,j) therefore performs step k of its dot product in cycle i+j+k after the feed begins. Each partial sum of C stays in its own cell.

When cell (i,j) takes its final product, the finished value is copied into a separate drain path. The accumulator is then free for the next tile. Each grid row owns a drain chain with two registers per cell, and that chain moves results toward the right edge. A per-row deskew delay lines up all rows at the output. The output is one column of C per cycle, on N lanes, with a single valid flag. Tiles may be issued back to back, one every N cycles. Draining one tile overlaps the accumulation of the next, and the output stream has no gaps.

Top module: `gemm_os_array`

## Requirements
- R1: After synchronous reset, `c_valid` is low and `c_col` is zero until a tile has been fed.
- R2: Each tile yields C[i][j] = sum over k of A[i][k]·B[k][j], with products and sums taken modulo 2^W and no saturation (with W=16, all-ones operands at N=3 give 3 in every element).
- R3: Lane i of `c_col` (bits [i*W +: W]) carries row i of C. Each tile raises `c_valid` for exactly N consecutive cycles, and these present column N-1 first and column 0 last.
- R4: The first column of a tile appears on the outputs 3N-1 clock edges after the edge that samples `start`.
- R5: `start` high marks beat 0. On beat k, lane r of `a_col` is A[r][k] and lane c of `b_row` is B[k][c]. Beats 1..N-1 follow on the next N-1 cycles without any further strobe.
- R6: A new `start` may arrive N cycles after the previous one. The accumulators restart on the new tile's first product, so each tile's result is independent of earlier tiles, and the output columns follow on without a gap.
- R7: A `start` pulse during beats 1..N-1 of a tile is ignored.
- R8: Values on `a_col` and `b_row` outside the N beats of a tile have no effect on any result. The feeders insert zeros in their place.
- R9: A reset during a tile discards that tile, and no `c_valid` follows for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks beat 0 of a tile |
| a_col | input | N*W | Column k of A, lane r = row r |
| b_row | input | N*W | Row k of B, lane c = column c |
| c_col | output | N*W | One column of C, lane i = row i |
| c_valid | output | 1 | `c_col` holds a result column |

## Verification
The assertions check several properties on every cycle. The feeders must deliver zero data whenever a lane is outside its tile window. The A and B valid flags must meet in each cell in the same cycle. A cell must never load a result into a drain slot that is already occupied. All rows must leave the deskew stage together. The beat counter must stay inside its range. Arithmetic results, column order, the 3N-1 cycle latency and the gap-free back-to-back stream can only be shown by the bench scenarios. These scenarios include random and all-ones tiles, stray start pulses, noise between tiles, and a reset in the middle of a tile, and each one is compared against a product computed in the bench.

// File: rtl/gemm_pkg.sv
`timescale 1ns/1ps
package gemm_pkg;
  // Control tag that travels with each A operand through the grid
  typedef struct packed {
    logic vld;    // operand belongs to a tile
    logic first;  // beat 0 of the tile
    logic last;   // beat N-1 of the tile
  } tag_t;
endpackage

// File: rtl/skew_line.sv
`timescale 1ns/1ps
module skew_line #(
  parameter int DEPTH = 1,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < DEPTH; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < DEPTH; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/gemm_feed_ctrl.sv
`timescale 1ns/1ps
module gemm_feed_ctrl #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic beat_ok,
  output logic beat_first,
  output logic beat_last
);
  localparam int KW = $clog2(N) + 1;

  logic          busy;
  logic [KW-1:0] kcnt;
  logic          take;

  always_comb begin
    take       = start && !busy;
    beat_ok    = take || busy;
    beat_first = take;
    beat_last  = (take && N == 1) || (busy && kcnt == KW'(N-1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      kcnt <= '0;
    end else if (take) begin
      busy <= (N > 1);
      kcnt <= KW'(1);
    end else if (busy) begin
      if (kcnt == KW'(N-1)) begin
        busy <= 1'b0;
        kcnt <= '0;
      end else begin
        kcnt <= kcnt + KW'(1);
      end
    end
  end

  // R7
  kcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (kcnt >= KW'(1) && kcnt <= KW'(N-1)));
endmodule

// File: rtl/gemm_pe.sv
`timescale 1ns/1ps
module gemm_pe import gemm_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  tag_t         a_tag_in,
  input  logic [W-1:0] b_in,
  input  logic         b_vin,
  input  logic [W-1:0] d_in,
  input  logic         d_vin,
  output logic [W-1:0] a_out,
  output tag_t         a_tag_out,
  output logic [W-1:0] b_out,
  output logic         b_vout,
  output logic [W-1:0] d_out,
  output logic         d_vout
);
  logic [W-1:0] acc, prod, sum;
  logic [W-1:0] d0, d1;
  logic         d0v, d1v;
  logic         load;

  always_comb begin
    prod = a_in * b_in;
    sum  = (a_tag_in.first ? '0 : acc) + prod;
    load = a_tag_in.vld && a_tag_in.last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out     <= '0;
      a_tag_out <= '0;
      b_out     <= '0;
      b_vout    <= 1'b0;
      acc       <= '0;
      d0        <= '0;
      d0v       <= 1'b0;
      d1        <= '0;
      d1v       <= 1'b0;
    end else begin
      a_out     <= a_in;
      a_tag_out <= a_tag_in;
      b_out     <= b_in;
      b_vout    <= b_vin;
      if (a_tag_in.vld) acc <= sum;
      if (load) begin
        d0  <= sum;
        d0v <= 1'b1;
      end else begin
        d0  <= d_in;
        d0v <= d_vin;
      end
      d1  <= d0;
      d1v <= d0v;
    end
  end

  assign d_out  = d1;
  assign d_vout = d1v;

  // R8
  pe_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    !a_tag_in.vld |-> (a_in == '0 && b_in == '0));
  // R5
  pe_operand_align_chk: assert property (@(posedge clk) disable iff (rst)
    a_tag_in.vld == b_vin);
  // R6
  drain_collision_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !d_vin);
endmodule

// File: rtl/gemm_os_array.sv
`timescale 1ns/1ps
module gemm_os_array import gemm_pkg::*; #(
  parameter int N = 3,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N*W-1:0] a_col,
  input  logic [N*W-1:0] b_row,
  output logic [N*W-1:0] c_col,
  output logic           c_valid
);
  localparam int TW = $bits(tag_t);
  localparam int AW = W + TW;
  localparam int BW = W + 1;

  logic beat_ok, beat_first, beat_last;
  tag_t feed_tag;

  logic [W-1:0] a_h  [N][N+1];
  tag_t         t_h  [N][N+1];
  logic [W-1:0] b_v  [N+1][N];
  logic         bv_v [N+1][N];
  logic [W-1:0] d_h  [N][N+1];
  logic         dv_h [N][N+1];
  logic [N-1:0] row_v;

  gemm_feed_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .beat_ok(beat_ok), .beat_first(beat_first), .beat_last(beat_last)
  );

  always_comb feed_tag = '{vld: beat_ok, first: beat_first, last: beat_last};

  genvar r, c;
  generate
    for (r = 0; r < N; r++) begin : g_arow
      logic [AW-1:0] fa_d, fa_q;
      assign fa_d = {feed_tag, (beat_ok ? a_col[r*W +: W] : {W{1'b0}})};
      skew_line #(.DEPTH(r+1), .W(AW)) u_fa (.clk(clk), .rst(rst), .d(fa_d), .q(fa_q));
      assign t_h[r][0]  = tag_t'(fa_q[AW-1:W]);
      assign a_h[r][0]  = fa_q[W-1:0];
      assign d_h[r][0]  = '0;
      assign dv_h[r][0] = 1'b0;
    end

    for (c = 0; c < N; c++) begin : g_bcol
      logic [BW-1:0] fb_d, fb_q;
      assign fb_d = {beat_ok, (beat_ok ? b_row[c*W +: W] : {W{1'b0}})};
      skew_line #(.DEPTH(c+1), .W(BW)) u_fb (.clk(clk), .rst(rst), .d(fb_d), .q(fb_q));
      assign bv_v[0][c] = fb_q[W];
      assign b_v[0][c]  = fb_q[W-1:0];
    end

    for (r = 0; r < N; r++) begin : g_prow
      for (c = 0; c < N; c++) begin : g_pcol
        gemm_pe #(.W(W)) u_pe (
          .clk(clk), .rst(rst),
          .a_in(a_h[r][c]), .a_tag_in(t_h[r][c]),
          .b_in(b_v[r][c]), .b_vin(bv_v[r][c]),
          .d_in(d_h[r][c]), .d_vin(dv_h[r][c]),
          .a_out(a_h[r][c+1]), .a_tag_out(t_h[r][c+1]),
          .b_out(b_v[r+1][c]), .b_vout(bv_v[r+1][c]),
          .d_out(d_h[r][c+1]), .d_vout(dv_h[r][c+1])
        );
      end
    end

    // Deskew: row r is N-1-r cycles early at the right edge
    for (r = 0; r < N; r++) begin : g_dsk
      if (r == N-1) begin : g_direct
        assign c_col[r*W +: W] = d_h[r][N];
        assign row_v[r]        = dv_h[r][N];
      end else begin : g_delay
        logic [W:0] dk_q;
        skew_line #(.DEPTH(N-1-r), .W(W+1)) u_dk (
          .clk(clk), .rst(rst), .d({dv_h[r][N], d_h[r][N]}), .q(dk_q));
        assign c_col[r*W +: W] = dk_q[W-1:0];
        assign row_v[r]        = dk_q[W];
      end

      // R8
      a_edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !t_h[r][N].vld |-> (a_h[r][N] == '0 && !t_h[r][N].first && !t_h[r][N].last));
    end

    for (c = 0; c < N; c++) begin : g_bedge
      // R8
      b_edge_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bv_v[N][c] |-> b_v[N][c] == '0);
    end
  endgenerate

  assign c_valid = row_v[0];

  // R3
  row_align_chk: assert property (@(posedge clk) disable iff (rst)
    (row_v == '0) || (row_v == '1));
endmodule

// File: tb/gemm_os_array_tb.sv
`timescale 1ns/1ps
module gemm_os_array_tb_top;
  localparam int N    = 3;
  localparam int W    = 16;
  localparam int MAXT = 64;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [N*W-1:0] a_col, b_row;
  logic [N*W-1:0] c_col;
  logic           c_valid;

  always #5 clk = ~clk;

  gemm_os_array #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .a_col(a_col), .b_row(b_row), .c_col(c_col), .c_valid(c_valid)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int issued = 0, done_t = 0, colcnt = 0, vcycles = 0;
  int st_edge [MAXT];
  logic [W-1:0] ec [MAXT][N][N];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Output monitor, samples on the falling edge
  always @(negedge clk) begin
    if (!rst && c_valid) begin
      vcycles++;
      if (done_t >= issued) begin
        chk(1'b0, "R3 unexpected valid", 1, 0);
      end else begin
        if (colcnt == 0)
          chk(cyc == st_edge[done_t] + 3*N - 1, "R4 latency", cyc, st_edge[done_t] + 3*N - 1);
        for (int i = 0; i < N; i++)
          chk(c_col[i*W +: W] == ec[done_t][i][N-1-colcnt], "R2/R3 result",
              c_col[i*W +: W], ec[done_t][i][N-1-colcnt]);
        colcnt++;
        if (colcnt == N) begin
          colcnt = 0;
          done_t++;
        end
      end
    end
  end

  // mode: 0 random, 1 all-ones, 2 identity A
  task automatic feed_tile(input int mode, input bit dup_start);
    logic [W-1:0] A [N][N];
    logic [W-1:0] B [N][N];
    logic [W-1:0] s;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        A[i][j] = (mode == 1) ? '1 : (mode == 2) ? W'(i == j) : W'($urandom);
        B[i][j] = (mode == 1) ? '1 : W'($urandom);
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        s = '0;
        for (int k = 0; k < N; k++) s = s + A[i][k] * B[k][j];
        ec[issued][i][j] = s;
      end
    st_edge[issued] = cyc + 1;
    issued++;
    for (int k = 0; k < N; k++) begin
      start = (k == 0) || (dup_start && k == 1);   // R7: second pulse ignored
      for (int r = 0; r < N; r++) begin
        a_col[r*W +: W] = A[r][k];
        b_row[r*W +: W] = B[k][r];
      end
      @(negedge clk);
    end
    start = 1'b0;
    a_col = {N{W'($urandom)}};   // R8: noise outside the window
    b_row = {N{W'($urandom)}};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      a_col = {N{W'($urandom)}};
      b_row = {N{W'($urandom)}};
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; a_col = '0; b_row = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(c_valid == 1'b0, "R1 valid after reset", c_valid, 0);
    chk(c_col == '0, "R1 data after reset", c_col, 0);

    feed_tile(2, 1'b0);            // R5 identity A
    idle(4*N);
    feed_tile(1, 1'b0);            // R2 wrap corner
    idle(4*N);
    for (int t = 0; t < 30; t++)   // R6 back to back
      feed_tile((t % 7 == 3) ? 1 : 0, (t % 3 == 1));
    for (int t = 0; t < 10; t++) begin
      feed_tile(0, 1'b0);
      idle(($urandom % 5) + 1);    // R8 noise in gaps
    end
    idle(5*N);
    chk(done_t == issued, "R3 tiles drained", done_t, issued);
    chk(vcycles == issued*N, "R3 valid cycle count", vcycles, issued*N);

    // R9: reset during a tile, nothing comes out
    start = 1'b1;
    a_col = {N{W'($urandom)}};
    b_row = {N{W'($urandom)}};
    @(negedge clk);
    start = 1'b0;
    idle(2);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 5*N; i++) begin
      chk(c_valid == 1'b0, "R9 no output after reset", c_valid, 0);
      @(negedge clk);
    end
    feed_tile(0, 1'b0);
    idle(5*N);
    chk(vcycles == issued*N, "R9 R3 valid count after reset", vcycles, issued*N);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule